// File: doc/BRIEF.md
# Masked LFSR Test Pattern Generator

This block is a self-test stimulus source for a module under test that takes a WIDTH-bit input word. A Fibonacci linear-feedback shift register produces a stream of pseudo-random words. A small compile-time mask table shapes that stream. Each mask entry holds a care vector, which selects the bit positions to force, and a value vector, which gives the forced levels. The mask entry also holds the length of its phase.

A session starts with a start pulse. The first phase (phase 0) emits N0 plain pseudo-random words. Each mask then gets one contiguous phase of its own length. During a mask phase the care positions carry the forced values and every other bit comes straight from the shift register. The shift register is never reseeded inside a session, so the free bits keep getting fresh values across phase boundaries.

One word is emitted per clock while valid is high. When the session ends, a done flag rises and holds until the next start. A start pulse during a session aborts that session and begins again from the seed.

Top module: `mlfsr_tpg`

## Requirements
- R1: While reset is asserted and after its release, before any start, valid_o and done_o are 0 and phase_o is 0.
- R2: The shift register moves one place toward the MSB on each step. The new bit 0 is the XOR of bits 15, 13, 12 and 10, which is a maximal-length sequence for 16 bits. The word in the first cycle after a start pulse is the seed (default 16'hACE1), and each later cycle shows the next step.
- R3: Phase 0 lasts N0 cycles (default 12), and during it pattern_o equals the raw shift-register word.
- R4: In mask phase i, every bit whose care bit is 1 equals the value bit, and every other bit equals the shift-register bit. The defaults are: mask 1 has care 16'h00F0 and value 16'h00A0; mask 2 has care 16'h8001 and value 16'h8000; mask 3 has care 16'h0F00 and value 16'h0500.
- R5: The phases run in the order 0, 1, ..., NMASK, each as one unbroken group. phase_o shows the current index. The default mask lengths are 5, 3 and 4 cycles, and every phase length must be at least 1.
- R6: The shift register keeps advancing across phase boundaries with no reseed. The first word of a mask phase continues the sequence from the last word of the previous phase.
- R7: The cycle after the last word of the last mask, valid_o is 0 and done_o is 1. done_o stays 1 and valid_o stays 0 until the next start.
- R8: A start pulse during a session restarts it. The next cycle shows phase 0 with the seed word, and the full session follows.
- R9: A seed parameter of 0 is replaced by 16'h0001. The first two words are then 16'h0001 and 16'h0002.
- R10: A session emits exactly N0 plus the sum of the mask lengths valid words (24 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Single-cycle pulse that begins or restarts a session |
| pattern_o | output | WIDTH | Test word for the module under test |
| valid_o | output | 1 | High while pattern_o carries a session word |
| phase_o | output | PW | Current phase: 0 for plain pseudo-random, i for mask i |
| done_o | output | 1 | High from the end of a session until the next start |

## Verification
The assertions check four rules on every cycle:
- done and valid are never high together, and done holds until a start.
- The phase index only stays the same or steps up by one while words are emitted.
- The shift register never reaches zero, and it reloads its seed after a start.
- During phase 0 the output is the unforced register word.

Only the bench scenarios can show the rest: the exact word sequence against an independent model of the feedback, the exact length of each phase, and the per-mask forcing. They also cover the continuity of the sequence across phase boundaries, the total session length, the restart in mid-session and the replacement of a zero seed.

// File: rtl/mlfsr_pkg.sv
package mlfsr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_END  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/mlfsr_shift.sv
module mlfsr_shift #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] word_o
);
  localparam logic [WIDTH-1:0] ONE_WORD = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] SEED_EFF = (SEED == '0) ? ONE_WORD : SEED;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             feedback;

  always_comb begin
    feedback = ^(state_q & TAPS);
    state_d  = state_q;
    if (load_i) begin
      state_d = SEED_EFF;
    end else if (step_i) begin
      state_d = {state_q[WIDTH-2:0], feedback};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_EFF;
    end else if (load_i || step_i) begin
      state_q <= state_d;
    end
  end

  assign word_o = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R2
  AST_SEED_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (state_q == SEED_EFF)); // R8
endmodule

// File: rtl/mlfsr_mask_rom.sv
module mlfsr_mask_rom #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned NMASK = 3,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned PW = 2,
  parameter logic [LEN_W-1:0] N0 = 16'd12,
  parameter logic [NMASK-1:0][WIDTH-1:0] MASK_CARE = '0,
  parameter logic [NMASK-1:0][WIDTH-1:0] MASK_VAL = '0,
  parameter logic [NMASK-1:0][LEN_W-1:0] MASK_LEN = '0
) (
  input  logic [PW-1:0]    phase_i,
  output logic [WIDTH-1:0] care_o,
  output logic [WIDTH-1:0] val_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned NPH = NMASK + 1;

  logic [WIDTH-1:0] care_tab [NPH];
  logic [WIDTH-1:0] val_tab  [NPH];
  logic [LEN_W-1:0] len_tab  [NPH];

  for (genvar g = 0; g < NPH; g++) begin : g_entry
    if (g == 0) begin : g_plain
      assign care_tab[g] = '0;
      assign val_tab[g]  = '0;
      assign len_tab[g]  = N0;
    end else begin : g_mask
      assign care_tab[g] = MASK_CARE[g-1];
      assign val_tab[g]  = MASK_VAL[g-1];
      assign len_tab[g]  = MASK_LEN[g-1];
    end
  end

  always_comb begin
    care_o = '0;
    val_o  = '0;
    len_o  = N0;
    for (int k = 0; k < NPH; k++) begin
      if (phase_i == PW'(k)) begin
        care_o = care_tab[k];
        val_o  = val_tab[k];
        len_o  = len_tab[k];
      end
    end
  end
endmodule

// File: rtl/mlfsr_seq.sv
module mlfsr_seq
  import mlfsr_pkg::*;
#(
  parameter int unsigned NMASK = 3,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned PW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PW-1:0]    phase_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             load_o,
  output logic             step_o
);
  localparam logic [PW-1:0] LAST_PH = PW'(NMASK);

  seq_state_t       st_q, st_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             last_in_phase;

  always_comb begin
    last_in_phase = (cnt_q == len_i - LEN_W'(1));
    st_d  = st_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (start_i) begin
      st_d  = SEQ_RUN;
      ph_d  = '0;
      cnt_d = '0;
    end else if (st_q == SEQ_RUN) begin
      if (last_in_phase) begin
        cnt_d = '0;
        if (ph_q == LAST_PH) begin
          st_d = SEQ_END;
        end else begin
          ph_d = ph_q + PW'(1);
        end
      end else begin
        cnt_d = cnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      ph_q  <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
  assign valid_o = (st_q == SEQ_RUN);
  assign done_o  = (st_q == SEQ_END);
  assign load_o  = start_i;
  assign step_o  = (st_q == SEQ_RUN) && !start_i;

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && valid_o)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R7
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !start_i) |=> (!valid_o || phase_o == $past(phase_o) ||
                              phase_o == $past(phase_o) + PW'(1))); // R5
endmodule

// File: rtl/mlfsr_tpg.sv
module mlfsr_tpg #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned NMASK = 3,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned PW = $clog2(NMASK + 1),
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1,
  parameter logic [LEN_W-1:0] N0 = 16'd12,
  parameter logic [NMASK-1:0][WIDTH-1:0] MASK_CARE = {16'h0F00, 16'h8001, 16'h00F0},
  parameter logic [NMASK-1:0][WIDTH-1:0] MASK_VAL  = {16'h0500, 16'h8000, 16'h00A0},
  parameter logic [NMASK-1:0][LEN_W-1:0] MASK_LEN  = {16'd4, 16'd3, 16'd5}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [WIDTH-1:0] pattern_o,
  output logic             valid_o,
  output logic [PW-1:0]    phase_o,
  output logic             done_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic [WIDTH-1:0] lfsr_word;
  logic [WIDTH-1:0] care_w, val_w;
  logic [LEN_W-1:0] len_w;
  logic             load_w, step_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  mlfsr_seq #(.NMASK(NMASK), .LEN_W(LEN_W), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i), .len_i(len_w),
    .phase_o(phase_o), .valid_o(valid_o), .done_o(done_o),
    .load_o(load_w), .step_o(step_w)
  );

  mlfsr_shift #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .load_i(load_w), .step_i(step_w),
    .word_o(lfsr_word)
  );

  mlfsr_mask_rom #(
    .WIDTH(WIDTH), .NMASK(NMASK), .LEN_W(LEN_W), .PW(PW), .N0(N0),
    .MASK_CARE(MASK_CARE), .MASK_VAL(MASK_VAL), .MASK_LEN(MASK_LEN)
  ) u_rom (
    .phase_i(phase_o), .care_o(care_w), .val_o(val_w), .len_o(len_w)
  );

  always_comb begin
    pattern_o = (lfsr_word & ~care_w) | (val_w & care_w);
  end

  AST_PR_UNFORCED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (valid_o && phase_o == '0) |-> (pattern_o == lfsr_word)); // R3
endmodule

// File: tb/mlfsr_tpg_test.sv
`timescale 1ns/1ps
module mlfsr_tpg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, start_z;
  logic [15:0] pat, pat_z;
  logic        valid, valid_z, done, done_z;
  logic [1:0]  phase, phase_z;
  int          total = 0;
  int          fails = 0;
  logic [15:0] m;

  localparam logic [15:0] TB_LEN  [4] = '{16'd12, 16'd5, 16'd3, 16'd4};
  localparam logic [15:0] TB_CARE [4] = '{16'h0000, 16'h00F0, 16'h8001, 16'h0F00};
  localparam logic [15:0] TB_VAL  [4] = '{16'h0000, 16'h00A0, 16'h8000, 16'h0500};
  localparam logic [15:0] SEED = 16'hACE1;

  always #4 clk = ~clk;

  mlfsr_tpg uut (.clk(clk), .rst_n(rst_n), .start_i(start), .pattern_o(pat),
                 .valid_o(valid), .phase_o(phase), .done_o(done));
  mlfsr_tpg #(.SEED(16'h0000)) uut_z (.clk(clk), .rst_n(rst_n), .start_i(start_z),
                 .pattern_o(pat_z), .valid_o(valid_z), .phase_o(phase_z), .done_o(done_z));

  function automatic logic [15:0] nxt(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m = SEED;
  endtask

  task automatic walk(input int limit);
    int n = 0;
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < int'(TB_LEN[p]); k++) begin
        if (n == limit) return;
        chk({31'd0, valid}, 32'd1, "R5 valid in session");
        chk({30'd0, phase}, p, "R5 phase index");
        chk({16'd0, pat}, {16'd0, (m & ~TB_CARE[p]) | (TB_VAL[p] & TB_CARE[p])},
            p == 0 ? "R3 plain word" : (k == 0 ? "R6 continuity at mask entry" : "R4 masked word"));
        m = nxt(m);
        n++;
        @(negedge clk);
      end
    end
    chk(n, 24, "R10 session length");
    chk({31'd0, valid}, 32'd0, "R7 valid low at end");
    chk({31'd0, done}, 32'd1, "R7 done high at end");
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_z = 1'b0;
    repeat (3) @(negedge clk);
    chk({31'd0, valid}, 0, "R1 valid in reset");
    chk({31'd0, done}, 0, "R1 done in reset");
    chk({30'd0, phase}, 0, "R1 phase in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({31'd0, valid}, 0, "R1 valid idle");
    chk({31'd0, done}, 0, "R1 done idle");

    pulse_start();
    chk({16'd0, pat}, {16'd0, SEED}, "R2 first word is seed");
    walk(1000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({31'd0, done}, 1, "R7 done holds");
      chk({31'd0, valid}, 0, "R7 valid stays low");
    end

    pulse_start();
    chk({31'd0, done}, 0, "R7 done cleared by start");
    walk(7);
    pulse_start();
    chk({16'd0, pat}, {16'd0, SEED}, "R8 restart reloads seed");
    chk({30'd0, phase}, 0, "R8 restart phase 0");
    walk(1000);

    start_z = 1'b1;
    @(negedge clk);
    start_z = 1'b0;
    chk({16'd0, pat_z}, 32'h0001, "R9 zero seed replaced");
    @(negedge clk);
    chk({16'd0, pat_z}, 32'h0002, "R9 second word");
    chk({16'd0, nxt(16'h0001)}, 32'h0002, "R2 model step");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule